// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block surrounds an embedded core with a ring of boundary cells so that the core logic and the chip interconnect around it can each be tested on their own. Every core input terminal and every core output terminal has its own cell. The cells are linked into one serial scan path between `wsi_i` and `wso_o`. A two-bit instruction register is loaded serially through the same pins and selects one of four modes: functional pass-through, interconnect test, core-internal test, or a one-flop bypass.

A test access port controller outside the block drives the shift, capture and update strobes. It also drives `instr_sel_i`, which steers those strobes to the instruction register instead of the data path. Every action takes place on the rising edge of the test clock. Each cell holds a shift flop and an update stage. The shift flop moves along the serial path. The update stage alone drives the terminals, so the terminal values do not ripple while data is being shifted.

Top module: `core_test_wrapper`

## Requirements
- R1: After reset the mode is normal (code 2'b00), every update stage and shift flop holds 0, `core_in_o` equals `func_in_i`, `func_out_o` equals `core_out_i`, and `wso_o` is 0.
- R2: In normal mode (2'b00) and in bypass mode (2'b11), `core_in_o` follows `func_in_i` and `func_out_o` follows `core_out_i` combinationally.
- R3: The mode codes are 2'b00 normal, 2'b01 external test, 2'b10 internal test and 2'b11 bypass. The mode changes only on an edge where `update_i` and `instr_sel_i` are both high. Shifting the instruction register has no effect on the mode.
- R4: With `instr_sel_i` high, each shift edge moves `wsi_i` into instruction bit 1 and bit 1 into bit 0. `wso_o` shows bit 0. Shifting bit 0 and then bit 1 therefore loads the code.
- R5: In modes 00, 01 and 10 with `instr_sel_i` low, each shift edge moves the boundary path by one place. The order is `wsi_i`, then input cells 0 to NUM_IN-1, then output cells 0 to NUM_OUT-1, then `wso_o`, which shows the last shift flop.
- R6: In external test mode, a capture edge loads `func_in_i` into the input cells, and `func_out_o` is driven from the output cells' update stages.
- R7: In internal test mode, `core_in_o` is driven from the input cells' update stages, and a capture edge loads `core_out_i` into the output cells.
- R8: A capture edge leaves the input cells unchanged in internal test mode and leaves the output cells unchanged in external test mode. In normal mode, both groups capture.
- R9: A shift edge never changes `core_in_o` or `func_out_o`. The update stages take the shift flop values only on an update edge with `instr_sel_i` low and the mode not bypass.
- R10: In bypass mode, a shift edge with `instr_sel_i` low loads `wsi_i` into a single flop shown on `wso_o`, and the boundary cells are left unchanged.
- R11: `shift_i`, `capture_i` and `update_i` are never high together. An edge with none of them high changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| func_in_i | input | NUM_IN | Chip-side signals heading into the core |
| core_in_o | output | NUM_IN | Drives the core input terminals |
| core_out_i | input | NUM_OUT | Core output terminals |
| func_out_o | output | NUM_OUT | Drives the chip-side logic from the core side |
| wsi_i | input | 1 | Serial test data in |
| wso_o | output | 1 | Serial test data out |
| shift_i | input | 1 | Shift strobe |
| capture_i | input | 1 | Capture strobe |
| update_i | input | 1 | Update strobe |
| instr_sel_i | input | 1 | Steers the strobes to the instruction register |

## Verification
The assertions assume that the three strobes are never high together. They also assume that the mode can change only through an update edge with instruction select high. The stimulus draws at most one strobe per cycle: shift, capture, update or idle. `instr_sel_i` is set at random about one cycle in five, and fresh random values are placed on the functional inputs every cycle. The bench model advances the instruction register, the bypass flop and the boundary cells from the same strobe rules. It therefore predicts all three outputs every cycle, including the cycles during a shift.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
  localparam int unsigned IR_W = 2;

  typedef enum logic [IR_W-1:0] {
    MODE_NORMAL = 2'b00,
    MODE_EXTEST = 2'b01,
    MODE_INTEST = 2'b10,
    MODE_BYPASS = 2'b11
  } ctw_mode_e;
endpackage

// File: rtl/ctw_cell.sv
module ctw_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic capture_en_i,
  input  logic update_en_i,
  input  logic si_i,
  input  logic cap_d_i,
  output logic sh_o,
  output logic upd_o
);
  logic sh_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sh_q <= 1'b0;
    else if (shift_en_i)   sh_q <= si_i;
    else if (capture_en_i) sh_q <= cap_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          upd_q <= 1'b0;
    else if (update_en_i) upd_q <= sh_q;
  end

  assign sh_o  = sh_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/ctw_instr_reg.sv
module ctw_instr_reg
  import ctw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      shift_en_i,
  input  logic      update_en_i,
  input  logic      si_i,
  output logic      so_o,
  output ctw_mode_e mode_o
);
  logic [IR_W-1:0] sh_q;
  ctw_mode_e       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sh_q <= '0;
    else if (shift_en_i) sh_q <= {si_i, sh_q[IR_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mode_q <= MODE_NORMAL;
    else if (update_en_i) mode_q <= ctw_mode_e'(sh_q);
  end

  assign so_o   = sh_q[0];
  assign mode_o = mode_q;
endmodule

// File: rtl/ctw_bypass.sv
module ctw_bypass (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic si_i,
  output logic so_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q <= 1'b0;
    else if (shift_en_i) q <= si_i;
  end

  assign so_o = q;
endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
  import ctw_pkg::*;
#(
  parameter int unsigned NUM_IN  = 8,
  parameter int unsigned NUM_OUT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IN-1:0]  func_in_i,
  output logic [NUM_IN-1:0]  core_in_o,
  input  logic [NUM_OUT-1:0] core_out_i,
  output logic [NUM_OUT-1:0] func_out_o,
  input  logic               wsi_i,
  output logic               wso_o,
  input  logic               shift_i,
  input  logic               capture_i,
  input  logic               update_i,
  input  logic               instr_sel_i
);
  localparam int unsigned CHAIN_LEN = NUM_IN + NUM_OUT;

  ctw_mode_e mode;
  logic      ir_so, byp_so;
  logic      bnd_sel, byp_sel;
  logic      cell_shift, cell_upd, in_cap, out_cap;
  logic [CHAIN_LEN:0]   chain;
  logic [CHAIN_LEN-1:0] upd_val;

  assign bnd_sel    = !instr_sel_i && (mode != MODE_BYPASS);
  assign byp_sel    = !instr_sel_i && (mode == MODE_BYPASS);
  assign cell_shift = shift_i  && bnd_sel;
  assign cell_upd   = update_i && bnd_sel;
  // input cells stay put in INTEST, output cells in EXTEST
  assign in_cap     = capture_i && bnd_sel && (mode != MODE_INTEST);
  assign out_cap    = capture_i && bnd_sel && (mode != MODE_EXTEST);

  ctw_instr_reg u_ir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_en_i  (shift_i && instr_sel_i),
    .update_en_i (update_i && instr_sel_i),
    .si_i        (wsi_i),
    .so_o        (ir_so),
    .mode_o      (mode)
  );

  ctw_bypass u_byp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_i && byp_sel),
    .si_i       (wsi_i),
    .so_o       (byp_so)
  );

  assign chain[0] = wsi_i;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in_cell
    ctw_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .shift_en_i   (cell_shift),
      .capture_en_i (in_cap),
      .update_en_i  (cell_upd),
      .si_i         (chain[i]),
      .cap_d_i      (func_in_i[i]),
      .sh_o         (chain[i+1]),
      .upd_o        (upd_val[i])
    );
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out_cell
    ctw_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .shift_en_i   (cell_shift),
      .capture_en_i (out_cap),
      .update_en_i  (cell_upd),
      .si_i         (chain[NUM_IN+j]),
      .cap_d_i      (core_out_i[j]),
      .sh_o         (chain[NUM_IN+j+1]),
      .upd_o        (upd_val[NUM_IN+j])
    );
  end

  assign core_in_o  = (mode == MODE_INTEST) ? upd_val[NUM_IN-1:0] : func_in_i;
  assign func_out_o = (mode == MODE_EXTEST) ? upd_val[CHAIN_LEN-1:NUM_IN] : core_out_i;

  always_comb begin
    if (instr_sel_i)              wso_o = ir_so;
    else if (mode == MODE_BYPASS) wso_o = byp_so;
    else                          wso_o = chain[CHAIN_LEN];
  end

  a_r11_ctrl_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({shift_i, capture_i, update_i}));

  a_r3_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(update_i && instr_sel_i) |=> $stable(mode));

  a_r9_intest_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_INTEST && shift_i) |=> $stable(core_in_o));

  a_r9_extest_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_EXTEST && shift_i) |=> $stable(func_out_o));

  a_r10_bypass_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_BYPASS && shift_i && !instr_sel_i)
      |=> (instr_sel_i || wso_o == $past(wsi_i)));
endmodule

// File: tb/tb_core_test_wrapper.sv
`timescale 1ns/1ps
module tb_core_test_wrapper;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int L  = NI + NO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] fin = '0;
  logic [NI-1:0] cin;
  logic [NO-1:0] cout = '0;
  logic [NO-1:0] fout;
  logic          wsi = 1'b0, wso;
  logic          sh = 1'b0, cap = 1'b0, upd = 1'b0, isel = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [L-1:0] m_sh  = '0;
  logic [L-1:0] m_upd = '0;
  logic [1:0]   m_ir  = '0;
  logic [1:0]   m_mode = '0;
  logic         m_byp = 1'b0;

  always #2.5 clk = ~clk;

  core_test_wrapper #(.NUM_IN(NI), .NUM_OUT(NO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .func_in_i(fin), .core_in_o(cin),
    .core_out_i(cout), .func_out_o(fout), .wsi_i(wsi), .wso_o(wso),
    .shift_i(sh), .capture_i(cap), .update_i(upd), .instr_sel_i(isel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NI-1:0] exp_cin(input logic [NI-1:0] f);
    return (m_mode == 2'b10) ? m_upd[NI-1:0] : f;
  endfunction

  function automatic logic [NO-1:0] exp_fout(input logic [NO-1:0] c);
    return (m_mode == 2'b01) ? m_upd[L-1:NI] : c;
  endfunction

  function automatic logic exp_wso(input logic s);
    if (s) return m_ir[0];
    if (m_mode == 2'b11) return m_byp;
    return m_sh[L-1];
  endfunction

  task automatic compare(input string tag);
    string t_in, t_out, t_so;
    t_in  = (tag != "") ? tag : (m_mode == 2'b10 ? "R7" : "R2");
    t_out = (tag != "") ? tag : (m_mode == 2'b01 ? "R6" : "R2");
    t_so  = (tag != "") ? tag : (isel ? "R4" : (m_mode == 2'b11 ? "R10" : "R5"));
    chk(t_in,  32'(cin),  32'(exp_cin(fin)));
    chk(t_out, 32'(fout), 32'(exp_fout(cout)));
    chk(t_so,  32'(wso),  32'(exp_wso(isel)));
  endtask

  task automatic step(input logic s, input logic c, input logic u, input logic is,
                      input logic d, input logic [NI-1:0] f, input logic [NO-1:0] co,
                      input string tag);
    @(negedge clk);
    sh = s; cap = c; upd = u; isel = is; wsi = d; fin = f; cout = co;
    if (is) begin
      if (s) m_ir = {d, m_ir[1]};
      if (u) m_mode = m_ir;
    end else if (m_mode == 2'b11) begin
      if (s) m_byp = d;
    end else begin
      if (s) m_sh = {m_sh[L-2:0], d};
      if (c) begin
        if (m_mode != 2'b10) m_sh[NI-1:0] = f;
        if (m_mode != 2'b01) m_sh[L-1:NI] = co;
      end
      if (u) m_upd = m_sh;
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic load_mode(input logic [1:0] code);
    step(1, 0, 0, 1, code[0], fin, cout, "R4");
    step(1, 0, 0, 1, code[1], fin, cout, "R3");
    step(0, 0, 1, 1, 0, fin, cout, "R3");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    fin = 4'hA; cout = 3'h5;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1", 32'(cin), 32'h A);
    chk("R1", 32'(fout), 32'h5);
    chk("R1", 32'(wso), 32'h0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 4'h3, 3'h6, "R2");

    // R3: shifting the instruction register without update keeps normal mode
    step(1, 0, 0, 1, 1, 4'h9, 3'h1, "R3");
    step(1, 0, 0, 1, 0, 4'h6, 3'h2, "R3");
    load_mode(2'b01);

    // R6: EXTEST capture of func_in, output cells held (R8), drive fout
    step(0, 1, 0, 0, 0, 4'hC, 3'h7, "R6");
    for (int k = 0; k < L; k++) step(1, 0, 0, 0, k[0], 4'h1, 3'h0, "R9");
    step(0, 0, 1, 0, 0, 4'h2, 3'h3, "R6");
    step(0, 1, 0, 0, 0, 4'h5, 3'h4, "R8");
    for (int k = 0; k < L; k++) step(1, 0, 0, 0, 1'b1, 4'h0, 3'h2, "R5");

    // R7: INTEST drive core_in from latches, capture core_out, inputs held
    load_mode(2'b10);
    for (int k = 0; k < L; k++) step(1, 0, 0, 0, ~k[1], 4'hF, 3'h1, "R9");
    step(0, 0, 1, 0, 0, 4'h0, 3'h6, "R7");
    step(0, 1, 0, 0, 0, 4'h7, 3'h5, "R8");
    for (int k = 0; k < L; k++) step(1, 0, 0, 0, 0, 4'h8, 3'h0, "R7");

    // R11: idle cycles change nothing
    step(0, 0, 0, 0, 1, 4'h4, 3'h2, "R11");
    step(0, 0, 0, 0, 1, 4'hB, 3'h3, "R11");

    // R10: bypass one-flop path, cells untouched
    load_mode(2'b11);
    step(1, 0, 0, 0, 1, 4'h1, 3'h1, "R10");
    step(1, 0, 0, 0, 0, 4'h2, 3'h2, "R10");
    step(1, 0, 0, 0, 1, 4'h3, 3'h3, "R10");
    step(0, 1, 0, 0, 0, 4'h6, 3'h4, "R10");
    load_mode(2'b01);
    step(0, 0, 0, 0, 0, 4'h0, 3'h0, "R10");

    // back to normal
    load_mode(2'b00);
    step(0, 1, 0, 0, 0, 4'hD, 3'h5, "R8");
    step(1, 0, 0, 0, 0, 4'hD, 3'h5, "R2");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic s, c, u, is;
      op = int'($urandom_range(0, 9));
      s = (op <= 4); c = (op == 5 || op == 6); u = (op == 7 || op == 8);
      is = ($urandom_range(0, 4) == 0);
      step(s, c, u, is, 1'($urandom), NI'($urandom), NO'($urandom), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule